// File: doc/BRIEF.md
# Selectable-Order Ramp Conversion Sequencer

This block is the digital controller for a ramp-type converter. The ramp can be taken from the first, second or third stage of a chain of integrators, so it rises linearly, quadratically or cubically in time. Each stage feeds its own comparator, which is set while its ramp is above the analog input. The sequencer discharges the integrators for a fixed number of clocks. It then lets them integrate the reference and counts clock edges until the chosen comparator trips. The count is the sample, and the sequence then repeats with no outside trigger.

The comparator outputs are asynchronous to the clock. The chosen one passes through a synchronizer, and the reported code is corrected for the synchronizer's latency. A conversion that runs out of count range returns the all-ones code together with an overflow flag.

Top module: `ramp_adc_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `integ_clear` is 1, `integ_run` is 0, `code_valid` is 0, `code` is 0 and `code_ovf` is 0.
- R2: Every conversion starts with a discharge phase that lasts exactly CLEAR_CYCLES clocks (default 4). In that phase `integ_clear` is 1 and `integ_run` is 0, and the count and the synchronizer are emptied. `integ_run` is 1 for the rest of the conversion, and the two outputs are never both 1 or both 0.
- R3: Call T the number of rising clock edges during which `integ_run` was 1 and the selected raw comparator was 0. A result that is not an overflow reports `code` = T, with the synchronizer latency removed.
- R4: `order_sel` encoding: 0 selects `cmp_lin`, 1 selects `cmp_quad`, 2 selects `cmp_cube`, and 3 selects `cmp_lin`. The comparators that are not selected have no effect on the result.
- R5: `order_sel` is sampled only during the discharge phase. A change made while `integ_run` is 1 leaves the current result unchanged and applies to the next conversion.
- R6: Each result raises `code_valid` for exactly one clock. The block then returns to the discharge phase by itself. `code` and `code_ovf` hold their values until the next result.
- R7: Let MAX be 2^CODE_W-1. If T would reach MAX-1 or more, the result is `code` = MAX (all ones) with `code_ovf` = 1. Any T of MAX-2 or less is reported normally with `code_ovf` = 0. The conversion that follows an overflow starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 2 | Ramp order select (0 linear, 1 quadratic, 2 cubic, 3 linear) |
| cmp_lin | input | 1 | Asynchronous comparator, first-stage ramp above input |
| cmp_quad | input | 1 | Asynchronous comparator, second-stage ramp above input |
| cmp_cube | input | 1 | Asynchronous comparator, third-stage ramp above input |
| integ_clear | output | 1 | Discharge command to the integrators |
| integ_run | output | 1 | Reference integration enable |
| code | output | CODE_W | Latched conversion result |
| code_valid | output | 1 | One-cycle strobe when a new result is latched |
| code_ovf | output | 1 | Result was out of count range |

## Verification
The bench models the three integrators as ramps that rise by k, k²/2 and k³/6 after k counted edges. The expected code is the first k at which the chosen ramp exceeds the input. If the design forgot the synchronizer correction, every code would read two high. A wrong multiplexer would return the answer for a different order, since the comparators that are not selected trip at other times. The bench changes `order_sel` in the middle of a conversion, which catches a design that samples the select live: it would return a code from the new order. The bench also runs the two inputs on either side of the overflow threshold, where an off-by-one in the limit shows up as a false or a missed all-ones code, and it checks that the conversion after an overflow starts again from zero.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [1:0] {
        ORD_LIN  = 2'd0,
        ORD_QUAD = 2'd1,
        ORD_CUBE = 2'd2
    } ramp_order_e;

    typedef enum logic {
        PH_CLEAR = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    typedef struct packed {
        logic valid;
        logic ovf;
    } result_flags_t;

    function automatic ramp_order_e decode_order(input logic [1:0] sel);
        case (sel)
            2'd1:    return ORD_QUAD;
            2'd2:    return ORD_CUBE;
            default: return ORD_LIN;
        endcase
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clr) chain <= '0;
                else            chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst || clr) chain <= '0;
                else            chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clear_timer.sv
module clear_timer #(
    parameter int CLEAR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int TW = $clog2(CLEAR_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(CLEAR_CYCLES - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || !active || done) tick <= '0;
        else                        tick <= tick + 1'b1;
    end

    assign done = active && (tick == LAST);

    // R2: the discharge counter never passes its last value
    assert_timer_bound_R2: assert property (@(posedge clk) disable iff (rst)
        tick <= LAST);
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [CODE_W-1:0] cnt,
    output logic              at_max
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_max = &cnt;

    // R7: the count must never wrap back to zero while running
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (at_max && !clr) |=> (cnt != '0));
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W       = 10,
    parameter int CLEAR_CYCLES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        order_sel,
    input  logic              cmp_lin,
    input  logic              cmp_quad,
    input  logic              cmp_cube,
    output logic              integ_clear,
    output logic              integ_run,
    output logic [CODE_W-1:0] code,
    output logic              code_valid,
    output logic              code_ovf
);
    localparam logic [CODE_W-1:0] LATENCY  = CODE_W'(SYNC_STAGES);
    localparam logic [CODE_W-1:0] ALL_ONES = '1;

    phase_e         phase_q;
    ramp_order_e    order_q;
    result_flags_t  flags_q;
    logic           raw_cmp;
    logic           tripped;
    logic           clear_done;
    logic           in_clear;
    logic           in_run;
    logic [CODE_W-1:0] cnt;
    logic           cnt_max;

    assign in_clear = (phase_q == PH_CLEAR);
    assign in_run   = (phase_q == PH_RUN);

    // comparator multiplexer, selection frozen during the run phase
    always_comb begin
        case (order_q)
            ORD_QUAD: raw_cmp = cmp_quad;
            ORD_CUBE: raw_cmp = cmp_cube;
            default:  raw_cmp = cmp_lin;
        endcase
    end

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .clr (in_clear),
        .d   (raw_cmp),
        .q   (tripped)
    );

    clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (in_clear),
        .done   (clear_done)
    );

    ramp_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (in_clear),
        .inc    (in_run && !tripped && !cnt_max),
        .cnt    (cnt),
        .at_max (cnt_max)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CLEAR;
            order_q <= ORD_LIN;
            flags_q <= '0;
            code    <= '0;
        end else begin
            flags_q.valid <= 1'b0;
            case (phase_q)
                PH_CLEAR: begin
                    order_q <= decode_order(order_sel);
                    if (clear_done) phase_q <= PH_RUN;
                end
                default: begin
                    if (tripped) begin
                        code          <= cnt - LATENCY;
                        flags_q.valid <= 1'b1;
                        flags_q.ovf   <= 1'b0;
                        phase_q       <= PH_CLEAR;
                    end else if (cnt_max) begin
                        code          <= ALL_ONES;
                        flags_q.valid <= 1'b1;
                        flags_q.ovf   <= 1'b1;
                        phase_q       <= PH_CLEAR;
                    end
                end
            endcase
        end
    end

    assign integ_clear = in_clear;
    assign integ_run   = in_run;
    assign code_valid  = flags_q.valid;
    assign code_ovf    = flags_q.ovf;

    // R2: exactly one of discharge and integrate is commanded
    assert_phase_excl_R2: assert property (@(posedge clk) disable iff (rst)
        integ_clear ^ integ_run);

    // R2: integration always begins from an empty count
    assert_count_zero_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(integ_run) |-> (cnt == '0));

    // R5: ramp order cannot change once integration is under way
    assert_order_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (integ_run && $past(integ_run)) |-> $stable(order_q));

    // R6: result strobe lasts a single clock
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);

    // R7: an overflow result always carries the all-ones code
    assert_ovf_code_R7: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_ovf) |-> (code == ALL_ONES));
endmodule

// File: tb/test_ramp_adc_seq.sv
module test_ramp_adc_seq;
    localparam int CODE_W = 10;
    localparam int CLEAR_CYCLES = 4;
    localparam int MAXC = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] order_sel = 2'd0;
    logic cmp_lin, cmp_quad, cmp_cube;
    logic integ_clear, integ_run, code_valid, code_ovf;
    logic [CODE_W-1:0] code;

    int vin = 0;
    int k = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ramp_adc_seq #(.CODE_W(CODE_W), .CLEAR_CYCLES(CLEAR_CYCLES), .SYNC_STAGES(2)) i_ramp_adc_seq (
        .clk(clk), .rst(rst), .order_sel(order_sel),
        .cmp_lin(cmp_lin), .cmp_quad(cmp_quad), .cmp_cube(cmp_cube),
        .integ_clear(integ_clear), .integ_run(integ_run),
        .code(code), .code_valid(code_valid), .code_ovf(code_ovf)
    );

    // integrator model: k = edges counted while integrating
    function automatic int ramp(input int ord, input int t);
        if (ord == 1)      return t * t / 2;
        else if (ord == 2) return t * t * t / 6;
        else               return t;
    endfunction

    always @(posedge clk) begin
        if (integ_run) k <= k + 1;
        else           k <= 0;
    end

    assign cmp_lin  = ramp(0, k) > vin;
    assign cmp_quad = ramp(1, k) > vin;
    assign cmp_cube = ramp(2, k) > vin;

    function automatic int sel_to_ord(input int s);
        return (s == 1) ? 1 : (s == 2) ? 2 : 0;
    endfunction

    function automatic int trip_time(input int ord, input int v);
        for (int t = 1; t < 4000; t++)
            if (ramp(ord, t) > v) return t;
        return 4000;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!code_valid);
    endtask

    task automatic check_result(input int ord, input int v, input string tag);
        int t;
        int exp_code;
        int exp_ovf;
        t = trip_time(ord, v);
        exp_ovf  = (t >= MAXC - 1) ? 1 : 0;
        exp_code = exp_ovf ? MAXC : t;
        check(int'(code) == exp_code, {tag, " code"}, int'(code), exp_code);
        check(int'(code_ovf) == exp_ovf, {tag, " R7 ovf flag"}, int'(code_ovf), exp_ovf);
        @(negedge clk);
        check(code_valid == 1'b0, "R6 strobe one cycle", int'(code_valid), 0);
        check(int'(code) == exp_code, "R6 code held", int'(code), exp_code);
    endtask

    // sets inputs at a result boundary and checks the following conversion
    task automatic run_conv(input int s, input int v, input string tag);
        wait_valid();
        order_sel = 2'(s);
        vin = v;
        wait_valid();
        check_result(sel_to_ord(s), v, tag);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(integ_clear == 1'b1, "R1 clear in reset", int'(integ_clear), 1);
        check(integ_run == 1'b0, "R1 run in reset", int'(integ_run), 0);
        check(code_valid == 1'b0, "R1 valid in reset", int'(code_valid), 0);
        check(int'(code) == 0, "R1 code in reset", int'(code), 0);
        check(code_ovf == 1'b0, "R1 ovf in reset", int'(code_ovf), 0);
        rst = 1'b0;
        @(negedge clk);
        check(integ_clear == 1'b1 && integ_run == 1'b0, "R1 first cycle after reset", int'(integ_run), 0);
    endtask

    task automatic test_clear_len();
        int n;
        wait_valid();
        n = 0;
        while (integ_clear) begin
            if (integ_run) check(1'b0, "R2 run during clear", 1, 0);
            n++;
            @(negedge clk);
        end
        check(n == CLEAR_CYCLES, "R2 discharge length", n, CLEAR_CYCLES);
        check(integ_run == 1'b1, "R2 run after discharge", int'(integ_run), 1);
    endtask

    task automatic test_orders();
        run_conv(0, 37, "R3 linear");
        run_conv(1, 300, "R3 R4 quadratic");
        run_conv(2, 5000, "R3 R4 cubic");
        run_conv(3, 10, "R4 select 3 is linear");
        run_conv(0, 0, "R3 zero input");
    endtask

    task automatic test_sel_change();
        wait_valid();
        order_sel = 2'd1;
        vin = 800;
        do @(negedge clk); while (!integ_run);
        repeat (10) @(negedge clk);
        order_sel = 2'd2;
        wait_valid();
        check_result(1, 800, "R5 select change mid-run");
        wait_valid();
        check_result(2, 800, "R5 new select on next conversion");
    endtask

    task automatic test_overflow();
        run_conv(0, MAXC - 3, "R7 largest normal code");
        run_conv(0, MAXC - 2, "R7 first overflow");
        run_conv(0, 5, "R7 restart after overflow");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_clear_len();
        test_orders();
        test_sel_change();
        test_overflow();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule